// File: doc/BRIEF.md
# Configuration Register Slave on a Two-Wire Serial Bus

This block is a two-wire serial bus slave that holds seven 8-bit configuration registers for a clock-generation subsystem. A host writes the registers with a block-write transaction and reads them back with a block-read transaction. The block never stretches the clock. It drives the data line only by pulling it low, through an open-drain enable output. Both bus lines are sampled by the system clock through two-flop synchronizers. Start and stop conditions are taken from data-line edges seen while the clock line is high.

A write opens with the device address in write direction. Two bytes follow that must be present but whose values are thrown away: a command byte and a byte-count byte. Every later byte lands in the next register, counting up from register 0. The host may stop after any whole byte. A read opens with the device address in read direction. The slave then returns a byte count of 7, followed by registers 0 through 6, for as long as the host acknowledges.

All seven registers are visible on a flat parallel output. The fields of register 0 are also decoded onto dedicated pins. Control pins are plain levels. The block has no streaming interface, so it needs no valid/ready handshake.

Top module: `cfgi2c_slave`

## Requirements
- R1: The slave acknowledges address byte 0xD2 (write) and 0xD3 (read), meaning 7-bit address 0x69 with bit 0 as the direction bit. Any other address byte is left unacknowledged and the rest of that transaction changes no register.
- R2: In a write, the two bytes after the address (command, then count) are acknowledged and their values have no effect on which register receives the next data byte.
- R3: Data bytes of a write are stored in order starting at register 0. A stop after any complete byte keeps every byte already received.
- R4: Data bytes past the seventh are acknowledged and discarded; registers 0 to 6 keep the first seven data bytes.
- R5: A read returns the byte count 7 first, then registers 0 to 6 in order; any byte requested after register 6 reads as 0xFF.
- R6: The slave keeps sending bytes while the host acknowledges. After a not-acknowledge it releases the data line and stays released until the next start.
- R7: After reset register 0 holds 0x00, registers 1 to 6 hold 0xFF, and the data line is released.
- R8: Register 0 is decoded as follows: bit 7 = wide spread depth, {bit 2, bits 6:4} = 4-bit frequency code with bit 2 as MSB, bit 3 = frequency taken from register, bit 1 = spread enable, bit 0 = outputs high-impedance.
- R9: The data-line enable changes only while the synchronized clock line is low (or to release it at a start or stop). It is never asserted while the slave is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| regs_o | output | 56 | Registers 0..6, register n in bits 8n+7:8n |
| spread_wide_o | output | 1 | Register 0 bit 7 |
| freq_code_o | output | 4 | {register 0 bit 2, bits 6:4} |
| freq_from_reg_o | output | 1 | Register 0 bit 3 |
| spread_en_o | output | 1 | Register 0 bit 1 |
| outputs_hiz_o | output | 1 | Register 0 bit 0 |

## Verification
Every cycle, the assertions check the line discipline. The data-line enable holds steady through each high clock phase and is off in idle. It is on during the address acknowledge and off while the host's acknowledge is sampled. Every register write lands in range and is visible the next cycle. The bench scenarios are needed for the ordering and discard rules: ignored command and count bytes, sequential placement, overflow bytes, reads past the last register, and rejected addresses. They also cover the reset contents and the decoded fields of register 0.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WBYTE,
    ST_WACK,
    ST_RBYTE,
    ST_RACK
  } bus_st_e;
endpackage

// File: rtl/cfgi2c_sync.sv
// Oversamples the two bus lines and derives bus events.
module cfgi2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_p  <= scl_sh[STAGES-1];
      sda_p  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = ~scl_p & scl_s;
  assign scl_fall  = scl_p & ~scl_s;
  assign start_det = scl_p & scl_s & sda_p & ~sda_s;
  assign stop_det  = scl_p & scl_s & ~sda_p & sda_s;
endmodule

// File: rtl/cfgi2c_regfile.sv
// Configuration registers with reset defaults and a bounded read port.
module cfgi2c_regfile #(
  parameter int          NREG      = 7,
  parameter logic [7:0]  DEF_FIRST = 8'h00,
  parameter logic [7:0]  DEF_REST  = 8'hFF,
  localparam int         IW        = $clog2(NREG),
  localparam int         CW        = $clog2(NREG + 3) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [7:0]        wr_data,
  input  logic [CW-1:0]     rd_idx,
  output logic [7:0]        rd_data,
  output logic [NREG*8-1:0] regs_o
);
  logic [7:0] regs_w [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [7:0] DEF = (g == 0) ? DEF_FIRST : DEF_REST;
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= DEF;
      else if (wr_en && wr_idx == IW'(g)) q <= wr_data;
    end
    assign regs_w[g]        = q;
    assign regs_o[g*8 +: 8] = q;
  end

  assign rd_data = (rd_idx < CW'(NREG)) ? regs_w[rd_idx[IW-1:0]] : 8'hFF;

  assert_wr_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_idx) < NREG));

  assert_store_visible_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (regs_w[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/cfgi2c_proto.sv
// Bus protocol engine: address match, block write, block read.
module cfgi2c_proto
  import cfgi2c_pkg::*;
#(
  parameter int         NREG     = 7,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  localparam int        IW       = $clog2(NREG),
  localparam int        CW       = $clog2(NREG + 3) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [7:0]    wr_data,
  output logic [CW-1:0] rd_idx,
  input  logic [7:0]    rd_data,
  output logic          sda_oe
);
  localparam logic [7:0]    CNT_BYTE = 8'(NREG);
  localparam logic [CW-1:0] CNT_MAX  = '1;

  bus_st_e       st;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg, txreg;
  logic          rnw, mack;
  logic [CW-1:0] wcnt, rd_ptr, didx;
  logic          in_rng;

  assign didx   = wcnt - CW'(2);
  assign in_rng = (wcnt >= CW'(2)) && (didx < CW'(NREG));
  assign rd_idx = rd_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      txreg   <= '0;
      rnw     <= 1'b0;
      mack    <= 1'b0;
      wcnt    <= '0;
      rd_ptr  <= '0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        st     <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_ADDR: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (shreg[7:1] == DEV_ADDR) begin
                sda_oe <= 1'b1;
                rnw    <= shreg[0];
                st     <= ST_AACK;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rnw) begin
                txreg  <= CNT_BYTE;
                sda_oe <= ~CNT_BYTE[7];
                rd_ptr <= '0;
                st     <= ST_RBYTE;
              end else begin
                sda_oe <= 1'b0;
                wcnt   <= '0;
                st     <= ST_WBYTE;
              end
            end
          end
          ST_WBYTE: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              sda_oe  <= 1'b1;
              st      <= ST_WACK;
              wr_en   <= in_rng;
              wr_idx  <= didx[IW-1:0];
              wr_data <= shreg;
              if (wcnt != CNT_MAX) wcnt <= wcnt + CW'(1);
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              st     <= ST_WBYTE;
            end
          end
          ST_RBYTE: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                sda_oe <= 1'b0;
                st     <= ST_RACK;
              end else begin
                txreg  <= {txreg[6:0], 1'b0};
                sda_oe <= ~txreg[6];
                bitcnt <= bitcnt + 4'd1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                txreg  <= rd_data;
                sda_oe <= ~rd_data[7];
                bitcnt <= '0;
                if (rd_ptr != CNT_MAX) rd_ptr <= rd_ptr + CW'(1);
                st     <= ST_RBYTE;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_IDLE;
              end
            end
          end
          default: begin
            sda_oe <= 1'b0;
          end
        endcase
      end
    end
  end

  assert_idle_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);

  assert_oe_steady_scl_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));

  assert_addr_ack_driven_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_AACK) |-> sda_oe);

  assert_host_ack_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RACK) |-> !sda_oe);
endmodule

// File: rtl/cfgi2c_slave.sv
// Top: configuration register slave on a two-wire serial bus.
module cfgi2c_slave #(
  parameter int         NREG     = 7,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         STAGES   = 2,
  localparam int        IW       = $clog2(NREG),
  localparam int        CW       = $clog2(NREG + 3) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] regs_o,
  output logic              spread_wide_o,
  output logic [3:0]        freq_code_o,
  output logic              freq_from_reg_o,
  output logic              spread_en_o,
  output logic              outputs_hiz_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic [7:0]    wr_data, rd_data;
  logic [CW-1:0] rd_idx;

  cfgi2c_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  cfgi2c_proto #(.NREG(NREG), .DEV_ADDR(DEV_ADDR)) u_proto (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .sda_oe(sda_oe)
  );

  cfgi2c_regfile #(.NREG(NREG), .DEF_FIRST(8'h00), .DEF_REST(8'hFF)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .regs_o(regs_o)
  );

  assign spread_wide_o   = regs_o[7];
  assign freq_code_o     = {regs_o[2], regs_o[6:4]};
  assign freq_from_reg_o = regs_o[3];
  assign spread_en_o     = regs_o[1];
  assign outputs_hiz_o   = regs_o[0];
endmodule

// File: tb/sim_cfgi2c_slave.sv
module sim_cfgi2c_slave;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [55:0] regs_o;
  logic spread_wide_o, freq_from_reg_o, spread_en_o, outputs_hiz_o;
  logic [3:0] freq_code_o;
  wire sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  cfgi2c_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .regs_o(regs_o), .spread_wide_o(spread_wide_o), .freq_code_o(freq_code_o),
    .freq_from_reg_o(freq_from_reg_o), .spread_en_o(spread_en_o),
    .outputs_hiz_o(outputs_hiz_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] mdl  [7];
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];

  // {number of data bytes, seed}; data byte i = seed ^ (i * 8'h1D)
  localparam logic [11:0] VEC [4] = '{12'h73C, 12'h3C1, 12'h14B, 12'h57E};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic bit_cycle(input logic d, output logic s);
    sda_m = d; wq(Q);
    scl_m = 1'b1; wq(Q);
    s = sda_line; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic nack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
    bit_cycle(1'b1, nack);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b1, s);
      b[i] = s;
    end
    bit_cycle(~give_ack, s);
  endtask

  task automatic write_txn(input logic [7:0] cmd, input logic [7:0] cnt,
                           input int n, output int nacks);
    logic nk;
    nacks = 0;
    bus_start();
    send_byte(8'hD2, nk); nacks += int'(nk);
    send_byte(cmd, nk);   nacks += int'(nk);
    send_byte(cnt, nk);   nacks += int'(nk);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], nk); nacks += int'(nk);
    end
    bus_stop();
    for (int i = 0; i < n && i < 7; i++) mdl[i] = wbuf[i];
  endtask

  task automatic read_txn(input int n, output logic addr_nack);
    logic [7:0] b;
    bus_start();
    send_byte(8'hD3, addr_nack);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, b);
      rbuf[k] = b;
    end
    wq(3);
    chk("R6 data line released after not-acknowledge", 64'(sda_oe), 64'd0);
    bus_stop();
  endtask

  task automatic check_regs(input string tag);
    for (int i = 0; i < 7; i++) chk(tag, 64'(regs_o[i*8 +: 8]), 64'(mdl[i]));
  endtask

  task automatic check_readback();
    logic an;
    read_txn(8, an);
    chk("R1 read address acknowledged", 64'(an), 64'd0);
    chk("R5 leading byte count", 64'(rbuf[0]), 64'd7);
    for (int i = 0; i < 7; i++) chk("R5 read register", 64'(rbuf[1+i]), 64'(mdl[i]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int nacks;
    logic nk;
    mdl[0] = 8'h00;
    for (int i = 1; i < 7; i++) mdl[i] = 8'hFF;
    wq(5);
    rst_n = 1'b1;
    wq(5);

    // R7 / R8 reset state
    check_regs("R7 reset default");
    chk("R7 data line released at reset", 64'(sda_oe), 64'd0);
    chk("R8 reset freq code", 64'(freq_code_o), 64'd0);
    chk("R8 reset fields", 64'({spread_wide_o, freq_from_reg_o, spread_en_o, outputs_hiz_o}), 64'd0);

    // table-driven writes and readbacks: R2, R3, R5
    for (int v = 0; v < 4; v++) begin
      int n;
      n = int'(VEC[v][11:8]);
      for (int i = 0; i < n; i++) wbuf[i] = VEC[v][7:0] ^ (8'(i) * 8'h1D);
      write_txn(8'h5A, 8'hA5, n, nacks);
      chk("R2 all write bytes acknowledged", 64'(nacks), 64'd0);
      check_regs("R3 sequential store");
      check_readback();
    end

    // R2: different command/count values, data still starts at register 0
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    write_txn(8'h03, 8'h01, 3, nacks);
    chk("R2 command and count acknowledged", 64'(nacks), 64'd0);
    check_regs("R2 values ignored");

    // R1: foreign address not acknowledged, nothing stored
    bus_start();
    send_byte(8'hA4, nk);
    chk("R1 foreign address not acknowledged", 64'(nk), 64'd1);
    send_byte(8'h00, nk);
    send_byte(8'h00, nk);
    send_byte(8'hEE, nk);
    chk("R1 following byte not acknowledged", 64'(nk), 64'd1);
    bus_stop();
    check_regs("R1 registers untouched");

    // R4: overlong write
    for (int i = 0; i < 10; i++) wbuf[i] = 8'hA0 + 8'(i);
    write_txn(8'h00, 8'h00, 10, nacks);
    chk("R4 overflow bytes acknowledged", 64'(nacks), 64'd0);
    check_regs("R4 first seven kept");

    // R5: read past the last register returns 0xFF
    begin
      logic an;
      read_txn(10, an);
      chk("R5 count", 64'(rbuf[0]), 64'd7);
      chk("R5 register 6", 64'(rbuf[7]), 64'(mdl[6]));
      chk("R5 beyond register 6", 64'(rbuf[8]), 64'hFF);
      chk("R5 further beyond", 64'(rbuf[9]), 64'hFF);
    end

    // R8: register 0 = 0xD7 -> wide=1, code=4'hD, from_reg=0, spread=1, hiz=1
    wbuf[0] = 8'hD7;
    write_txn(8'h00, 8'h00, 1, nacks);
    chk("R8 spread depth", 64'(spread_wide_o), 64'd1);
    chk("R8 freq code", 64'(freq_code_o), 64'hD);
    chk("R8 freq source", 64'(freq_from_reg_o), 64'd0);
    chk("R8 spread enable", 64'(spread_en_o), 64'd1);
    chk("R8 outputs hiz", 64'(outputs_hiz_o), 64'd1);
    check_regs("R3 single byte write");
    chk("R9 released when idle", 64'(sda_oe), 64'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule